// File: doc/BRIEF.md
# Weighted Fairness Packet Budget Controller

This block decides, for a single bus node, whether the node may ask for the bus to send one more packet in the current fairness interval. An interval runs from one arbitration reset gap to the next. At each gap the node gets a packet allowance that depends on a 2-bit weight: a plain node gets one packet per interval, and heavier weights get 2, 4 or 8 packets. The allowance goes down by one on every packet actually sent. When it reaches zero, the request is withheld until the next gap.

The first packet of each interval is the fair one. Every later packet in the same interval is marked unfair, so the arbitration logic can treat it differently. The weight is sampled only at a gap, so changing it in the middle of an interval does nothing until the next gap. After reset the allowance is empty, and the node stays silent until it has seen its first gap.

Top module: `fair_budget_ctrl`

## Requirements
- R1: While reset is held and after it is released, `budget_o` is 0 and `arb_req_o` is 0 until the first gap pulse.
- R2: A cycle with `gap_i` high loads `budget_o`, in the next cycle, with the allowance for the `weight_i` value present at that edge. The mapping is 0→1, 1→2, 2→4 and 3→8.
- R3: A cycle with `sent_i` high, `gap_i` low and `budget_o` nonzero lowers `budget_o` by exactly one in the next cycle.
- R4: `arb_req_o` is high exactly when `pending_i` is high and `budget_o` is nonzero, in the same cycle (combinational).
- R5: A `sent_i` pulse while `budget_o` is 0 is ignored: the budget stays 0, with no wrap.
- R6: `unfair_tag_o` is 0 while no packet has been accepted since the last gap, and 1 once at least one has been, but only while `arb_req_o` is high. It is always 0 when `arb_req_o` is 0.
- R7: A change of `weight_i` in a cycle without a gap has no effect on `budget_o`.
- R8: When `gap_i` and `sent_i` are high in the same cycle, the gap wins. The budget reloads to the full allowance and the next request is tagged fair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| weight_i | input | 2 | Unfairness weight, sampled at a gap |
| gap_i | input | 1 | One-cycle pulse marking an arbitration reset gap |
| pending_i | input | 1 | A packet is waiting to go out |
| sent_i | input | 1 | One-cycle pulse when a packet has been sent |
| arb_req_o | output | 1 | Request to arbitrate for the bus |
| unfair_tag_o | output | 1 | The current request is an unfair (extra) packet |
| budget_o | output | 4 | Packets still allowed in this interval |

## Verification
The budget register is visible at `budget_o`, so a wrong reload value, a missed decrement or a wrap past zero shows up one cycle after the gap or send pulse that caused it. A wrong interval phase shows only through `unfair_tag_o`, and only while a request is up. The tests therefore keep `pending_i` high while they walk each weight's allowance down to zero. A late weight change and a gap that coincides with a send are each covered by a dedicated test, because both could leave a stale allowance without disturbing the ordinary count-down.

// File: rtl/fbc_pkg.sv
package fbc_pkg;
  // Where the node stands inside the current fairness interval.
  typedef enum logic [1:0] {
    IV_EMPTY = 2'd0,  // no interval opened since reset
    IV_FRESH = 2'd1,  // interval opened, nothing sent yet
    IV_USED  = 2'd2   // at least one packet sent in this interval
  } iv_phase_t;
endpackage

// File: rtl/fbc_budget_counter.sv
module fbc_budget_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reload_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             consume_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)         cnt_q <= '0;
    else if (reload_i)  cnt_q <= load_val_i;
    else if (consume_i) cnt_q <= cnt_q - CNT_W'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/fbc_interval_phase.sv
module fbc_interval_phase
  import fbc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      open_i,
  input  logic      consume_i,
  output iv_phase_t phase_o
);
  iv_phase_t phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n)         phase_q <= IV_EMPTY;
    else if (open_i)    phase_q <= IV_FRESH;
    else if (consume_i) phase_q <= IV_USED;
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/fbc_request_gate.sv
module fbc_request_gate
  import fbc_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             pending_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  iv_phase_t        phase_i,
  output logic             req_o,
  output logic             unfair_o
);
  logic have_budget;

  always_comb begin
    have_budget = (cnt_i != '0);
    req_o       = pending_i && have_budget;
    unfair_o    = req_o && (phase_i == IV_USED);
  end
endmodule

// File: rtl/fair_budget_ctrl.sv
module fair_budget_ctrl
  import fbc_pkg::*;
#(
  parameter int CODE_W = 2,
  localparam int MAX_BUDGET = 1 << ((1 << CODE_W) - 1),
  localparam int CNT_W = $clog2(MAX_BUDGET) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] weight_i,
  input  logic              gap_i,
  input  logic              pending_i,
  input  logic              sent_i,
  output logic              arb_req_o,
  output logic              unfair_tag_o,
  output logic [CNT_W-1:0]  budget_o
);
  // Allowance for a weight: a power of two.
  function automatic logic [CNT_W-1:0] allowance(input logic [CODE_W-1:0] w);
    return CNT_W'(1) << w;
  endfunction

  // Named internal events, kept visible for the checker.
  logic             reload_ev;
  logic             consume_ev;
  logic [CNT_W-1:0] load_val;
  iv_phase_t        phase;

  assign reload_ev  = gap_i;
  assign consume_ev = sent_i && !gap_i && (budget_o != '0);
  assign load_val   = allowance(weight_i);

  fbc_budget_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .reload_i   (reload_ev),
    .load_val_i (load_val),
    .consume_i  (consume_ev),
    .cnt_o      (budget_o)
  );

  fbc_interval_phase u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .open_i    (reload_ev),
    .consume_i (consume_ev),
    .phase_o   (phase)
  );

  fbc_request_gate #(.CNT_W(CNT_W)) u_gate (
    .pending_i (pending_i),
    .cnt_i     (budget_o),
    .phase_i   (phase),
    .req_o     (arb_req_o),
    .unfair_o  (unfair_tag_o)
  );
endmodule

// File: rtl/fair_budget_chk.sv
module fair_budget_chk #(
  parameter int CODE_W = 2,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CODE_W-1:0] weight_i,
  input logic              gap_i,
  input logic              pending_i,
  input logic              sent_i,
  input logic              arb_req_o,
  input logic              unfair_tag_o,
  input logic [CNT_W-1:0]  budget_o,
  input logic              consume_ev
);
  // R2: gap loads the power-of-two allowance
  p_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
    gap_i |=> budget_o == (CNT_W'(1) << $past(weight_i)));

  // R3: accepted send lowers budget by one
  p_decrement_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!gap_i && sent_i && budget_o != '0) |=> budget_o == $past(budget_o) - CNT_W'(1));

  // R4: no request without budget
  p_req_budget_r4: assert property (@(posedge clk) disable iff (!rst_n)
    arb_req_o |-> (budget_o != '0 && pending_i));

  // R5: empty budget stays empty until a gap
  p_no_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!gap_i && budget_o == '0) |=> budget_o == '0);

  // R6: first request after a gap is fair
  p_fair_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    gap_i |=> !unfair_tag_o);

  // R6: tag only with a request
  p_tag_needs_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    unfair_tag_o |-> arb_req_o);

  // R7: without gap or send the budget is frozen, whatever the weight does
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!gap_i && !sent_i) |=> $stable(budget_o));

  // R8: a gap suppresses consumption in the same cycle
  p_gap_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    gap_i |-> !consume_ev);
endmodule

bind fair_budget_ctrl fair_budget_chk #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .weight_i     (weight_i),
  .gap_i        (gap_i),
  .pending_i    (pending_i),
  .sent_i       (sent_i),
  .arb_req_o    (arb_req_o),
  .unfair_tag_o (unfair_tag_o),
  .budget_o     (budget_o),
  .consume_ev   (consume_ev)
);

// File: tb/sim_fair_budget_ctrl.sv
`timescale 1ns/1ps
module sim_fair_budget_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] weight_i = 2'd0;
  logic       gap_i = 1'b0;
  logic       pending_i = 1'b0;
  logic       sent_i = 1'b0;
  logic       arb_req_o;
  logic       unfair_tag_o;
  logic [3:0] budget_o;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  fair_budget_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .weight_i(weight_i), .gap_i(gap_i),
    .pending_i(pending_i), .sent_i(sent_i), .arb_req_o(arb_req_o),
    .unfair_tag_o(unfair_tag_o), .budget_o(budget_o)
  );

  // Allowance written as a lookup, independently of the RTL shift.
  function automatic int expect_allow(input int w);
    case (w)
      0: return 1;
      1: return 2;
      2: return 4;
      default: return 8;
    endcase
  endfunction

  task automatic chk(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d", req, got, exp);
    end
  endtask

  // Apply one cycle of pulses; results sampled 1 ns after the edge.
  task automatic cycle(input bit g, input bit s);
    gap_i  = g;
    sent_i = s;
    @(posedge clk);
    #1;
    gap_i  = 1'b0;
    sent_i = 1'b0;
  endtask

  task automatic t_reset();
    pending_i = 1'b1;
    chk("R1 budget in reset", budget_o, 0);
    chk("R1 req in reset", arb_req_o, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    cycle(0, 0);
    chk("R1 budget after reset", budget_o, 0);
    chk("R4 req with empty budget", arb_req_o, 0);
    cycle(0, 1);
    chk("R5 send before first gap", budget_o, 0);
  endtask

  task automatic t_weights();
    for (int w = 0; w < 4; w++) begin
      int left;
      pending_i = 1'b1;
      weight_i  = 2'(w);
      cycle(1, 0);
      left = expect_allow(w);
      chk("R2 reload value", budget_o, left);
      chk("R4 req with budget", arb_req_o, 1);
      chk("R6 first packet fair", unfair_tag_o, 0);
      while (left > 0) begin
        cycle(0, 1);
        left--;
        chk("R3 decrement", budget_o, left);
        chk("R4 req follows budget", arb_req_o, (left != 0) ? 1 : 0);
        chk("R6 later packet unfair", unfair_tag_o, (left != 0) ? 1 : 0);
      end
      cycle(0, 1);
      chk("R5 send at zero ignored", budget_o, 0);
      chk("R5 req stays low", arb_req_o, 0);
    end
  endtask

  task automatic t_weight_change();
    pending_i = 1'b1;
    weight_i  = 2'd1;
    cycle(1, 0);
    weight_i = 2'd3;
    cycle(0, 0);
    chk("R7 weight change mid interval", budget_o, 2);
    cycle(0, 1);
    chk("R7 decrement uses old allowance", budget_o, 1);
    cycle(1, 0);
    chk("R7 new weight at next gap", budget_o, 8);
  endtask

  task automatic t_collision();
    pending_i = 1'b1;
    weight_i  = 2'd2;
    cycle(1, 0);
    cycle(0, 1);
    chk("R3 one sent", budget_o, 3);
    chk("R6 unfair after send", unfair_tag_o, 1);
    cycle(1, 1);
    chk("R8 gap beats send", budget_o, 4);
    chk("R8 fair after collision", unfair_tag_o, 0);
  endtask

  task automatic t_pending_low();
    weight_i = 2'd3;
    cycle(1, 0);
    cycle(0, 1);
    pending_i = 1'b0;
    #1;
    chk("R4 no req without pending", arb_req_o, 0);
    chk("R6 no tag without req", unfair_tag_o, 0);
    chk("R3 budget kept", budget_o, 7);
    pending_i = 1'b1;
    #1;
    chk("R6 tag returns with req", unfair_tag_o, 1);
  endtask

  initial begin
    #1;
    t_reset();
    t_weights();
    t_weight_change();
    t_collision();
    t_pending_low();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule